// File: doc/BRIEF.md
# PS/2 Key Event Assembler

This block sits behind a PS/2 keyboard receiver that has already checked framing and parity. It takes each received byte, offered together with a one-cycle strobe, and builds complete key events from the prefix conventions of Scan Code Set 2. A prefix byte of 0xE0 marks an extended key. A prefix byte of 0xF0 marks a key release. The final, non-prefix byte carries the key code. So a plain press arrives as one byte, for example 0x1C for the A key. A plain release arrives as F0 xx, an extended press as E0 xx, and an extended release as E0 F0 xx.

For each finished sequence the block raises a one-cycle event strobe, registered one cycle after the strobe of the final byte. With it the block presents the key code, an extended flag and a release flag. The PAUSE key sequence starts with 0xE1 and has a fixed length. The block consumes that sequence byte by byte, marks each byte with an "unsupported" strobe and emits no key event for it. The PRINT SCREEN key wraps its code in extended "fake shift" codes (0x12 and 0x59). Those codes are also marked unsupported rather than reported as keys. Downstream logic such as ASCII translation or modifier tracking consumes only the event strobe.

Top module: `kbd_event_asm`

## Requirements
- R1: A non-prefix byte received with no prefix pending produces, one clock after its strobe, `evt_valid`=1 with `evt_code` equal to that byte, `evt_ext`=0 and `evt_rel`=0.
- R2: The sequence E0 xx (xx not a prefix, not 0xE1 and not a fake-shift code) produces one event with `evt_code`=xx, `evt_ext`=1 and `evt_rel`=0.
- R3: The sequence F0 xx produces one event with `evt_code`=xx, `evt_ext`=0 and `evt_rel`=1.
- R4: The sequence E0 F0 xx produces one event with `evt_code`=xx, `evt_ext`=1 and `evt_rel`=1. After any event the parser holds no prefix.
- R5: A prefix byte (0xE0 or 0xF0) produces neither `evt_valid` nor `unsup_stb` in the following cycle.
- R6: `evt_valid` is high for exactly one cycle per completed sequence. While it is low, `evt_code`, `evt_ext` and `evt_rel` are all zero.
- R7: A byte 0xE1 received outside a skip window, together with the next PAUSE_TAIL bytes (default 7), each raise `unsup_stb` for one cycle one clock after their strobe. None of them raises `evt_valid`. Any pending prefix is dropped. The parser then resumes normally.
- R8: A byte 0x12 or 0x59 that follows an E0 prefix, with or without an F0 between, raises `unsup_stb` instead of an event and clears the pending prefix.
- R9: In a cycle with `byte_stb` low, the value on `byte_in` is ignored, and the following cycle shows `evt_valid`=0 and `unsup_stb`=0.
- R10: Synchronous active-low reset clears all outputs, any pending prefix and any skip window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_in | input | 8 | Validated byte from the PS/2 receiver |
| byte_stb | input | 1 | One-cycle strobe: `byte_in` holds a new byte |
| evt_valid | output | 1 | One-cycle key event strobe |
| evt_code | output | 8 | Final key code byte of the event |
| evt_ext | output | 1 | Event came with the 0xE0 extended prefix |
| evt_rel | output | 1 | Event came with the 0xF0 release prefix |
| unsup_stb | output | 1 | One-cycle strobe: byte consumed as part of an unsupported sequence |

## Verification
The assertions assume that every byte strobe stands for one byte. They also assume that the receiver may deliver strobes on consecutive cycles. They do not assume that the keyboard sends only legal sequences. The random stimulus therefore mixes back-to-back strobes, idle gaps carrying junk on `byte_in`, and bytes drawn with a bias toward 0xE0, 0xF0, 0xE1, 0x12 and 0x59. This drives prefix chains, doubled prefixes and PAUSE windows that open inside a pending prefix. A bench model derived from the requirements follows the byte stream. Directed cases add resets in the middle of a prefix and in the middle of a PAUSE window.

// File: rtl/kbd_event_pkg.sv
// Package kbd_event_pkg
// Purpose : shared constants and the prefix-tracking state type of the
//           key event assembler.
// Assumes : Scan Code Set 2 byte values.
package kbd_event_pkg;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] BYTE_EXT   = 8'hE0;
    localparam logic [CODE_W-1:0] BYTE_REL   = 8'hF0;
    localparam logic [CODE_W-1:0] BYTE_PAUSE = 8'hE1;
    localparam logic [CODE_W-1:0] BYTE_FAKE_LSHIFT = 8'h12;
    localparam logic [CODE_W-1:0] BYTE_FAKE_RSHIFT = 8'h59;

    // Prefix state: which prefixes have been seen for the current key
    typedef enum logic [1:0] {
        PS_NONE    = 2'b00,
        PS_EXT     = 2'b01,
        PS_REL     = 2'b10,
        PS_EXT_REL = 2'b11
    } pfx_state_t;
endpackage

// File: rtl/kbd_pause_skip.sv
// Module  : kbd_pause_skip
// Purpose : recognises the start of the PAUSE key sequence (0xE1) and
//           swallows it together with the following TAIL bytes, flagging
//           each as unsupported.
// Assumes : byte_stb is a one-cycle strobe per byte; a 0xE1 seen inside
//           the window counts as a tail byte and does not reopen it.
module kbd_pause_skip
    import kbd_event_pkg::*;
#(
    parameter int TAIL = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              byte_stb,
    output logic              skip_now,   // this strobe is consumed here
    output logic              pause_open  // this strobe opened a window
);
    localparam int CNT_W = $clog2(TAIL + 1);
    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL);

    logic [CNT_W-1:0] remain;
    logic             in_window;

    assign in_window  = (remain != '0);
    assign pause_open = byte_stb && !in_window && (byte_in == BYTE_PAUSE);
    assign skip_now   = byte_stb && (in_window || (byte_in == BYTE_PAUSE));

    // Track how many tail bytes of the PAUSE sequence remain to be swallowed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (pause_open) begin
            remain <= TAIL_LOAD;
        end else if (byte_stb && in_window) begin
            remain <= remain - 1'b1;
        end
    end

    // R7: the window never holds more than the tail length
    p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= TAIL_LOAD);

    // R7: the window only shrinks on a byte strobe
    p_window_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_stb && in_window) |=> $stable(remain));
endmodule

// File: rtl/kbd_prefix_fsm.sv
// Module  : kbd_prefix_fsm
// Purpose : tracks the 0xE0 / 0xF0 prefixes of a key sequence and reports
//           a completed key (or a fake-shift code) on the final byte.
// Assumes : bytes belonging to a PAUSE window are withheld by the caller
//           (byte_stb low for them); flush drops any pending prefix.
module kbd_prefix_fsm
    import kbd_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              byte_stb,
    input  logic              flush,
    output logic              key_done,   // final byte of a real key
    output logic              fake_done,  // extended fake-shift code
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_rel
);
    pfx_state_t state_q, state_d;
    logic       is_ext_b, is_rel_b, is_fake_b, final_b;

    assign is_ext_b  = (byte_in == BYTE_EXT);
    assign is_rel_b  = (byte_in == BYTE_REL);
    assign is_fake_b = (byte_in == BYTE_FAKE_LSHIFT) ||
                       (byte_in == BYTE_FAKE_RSHIFT);
    assign final_b   = byte_stb && !flush && !is_ext_b && !is_rel_b;

    assign key_ext   = state_q[0];
    assign key_rel   = state_q[1];
    assign key_code  = byte_in;
    assign fake_done = final_b && key_ext && is_fake_b;
    assign key_done  = final_b && !(key_ext && is_fake_b);

    // Next prefix state: prefixes accumulate, a final byte or flush clears
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = PS_NONE;
        end else if (byte_stb) begin
            if (is_ext_b) begin
                state_d = pfx_state_t'({state_q[1], 1'b1});
            end else if (is_rel_b) begin
                state_d = pfx_state_t'({1'b1, state_q[0]});
            end else begin
                state_d = PS_NONE;
            end
        end
    end

    // Prefix state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // R4: a completed key always leaves the parser with no prefix pending
    p_idle_after_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_done || fake_done) |=> (state_q == PS_NONE));

    // R5: a prefix byte sets its flag for the next byte
    p_ext_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !flush && is_ext_b) |=> key_ext);
    p_rel_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !flush && is_rel_b) |=> key_rel);

    // R7: a flush leaves no prefix behind
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == PS_NONE));
endmodule

// File: rtl/kbd_event_out.sv
// Module  : kbd_event_out
// Purpose : registers the key event and the unsupported strobe, zeroing
//           the event fields in every cycle without an event.
// Assumes : key_done and unsup are never requested in the same cycle.
module kbd_event_out
    import kbd_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_done,
    input  logic [CODE_W-1:0] key_code,
    input  logic              key_ext,
    input  logic              key_rel,
    input  logic              unsup,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code,
    output logic              evt_ext,
    output logic              evt_rel,
    output logic              unsup_stb
);
    // Output register: capture the event fields only with the event strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= '0;
            evt_ext   <= 1'b0;
            evt_rel   <= 1'b0;
            unsup_stb <= 1'b0;
        end else begin
            evt_valid <= key_done;
            evt_code  <= key_done ? key_code : '0;
            evt_ext   <= key_done && key_ext;
            evt_rel   <= key_done && key_rel;
            unsup_stb <= unsup;
        end
    end

    // R6: event fields read zero whenever no event is presented
    p_quiet_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> (evt_code == '0 && !evt_ext && !evt_rel));

    // R7: an unsupported byte never doubles as a key event
    p_excl_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && unsup_stb));
endmodule

// File: rtl/kbd_event_asm.sv
// Module  : kbd_event_asm
// Purpose : top of the PS/2 key event assembler. Routes PAUSE bytes to
//           the skip counter, all others to the prefix tracker, and
//           registers the resulting event or unsupported strobe.
// Assumes : byte_in carries bytes already checked for framing and parity,
//           one per byte_stb pulse; strobes may come back to back.
module kbd_event_asm
    import kbd_event_pkg::*;
#(
    parameter int PAUSE_TAIL = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              byte_stb,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code,
    output logic              evt_ext,
    output logic              evt_rel,
    output logic              unsup_stb
);
    logic              skip_now, pause_open;
    logic              key_done, fake_done;
    logic [CODE_W-1:0] key_code;
    logic              key_ext, key_rel;

    kbd_pause_skip #(.TAIL(PAUSE_TAIL)) u_skip (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .byte_stb   (byte_stb),
        .skip_now   (skip_now),
        .pause_open (pause_open)
    );

    kbd_prefix_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (byte_in),
        .byte_stb  (byte_stb && !skip_now),
        .flush     (pause_open),
        .key_done  (key_done),
        .fake_done (fake_done),
        .key_code  (key_code),
        .key_ext   (key_ext),
        .key_rel   (key_rel)
    );

    kbd_event_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_done  (key_done),
        .key_code  (key_code),
        .key_ext   (key_ext),
        .key_rel   (key_rel),
        .unsup     (skip_now || fake_done),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .evt_ext   (evt_ext),
        .evt_rel   (evt_rel),
        .unsup_stb (unsup_stb)
    );

    // R9: without a byte strobe the next cycle is silent
    p_no_stb_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> (!evt_valid && !unsup_stb));

    // R5: prefix bytes never produce an event or unsupported strobe
    p_prefix_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !skip_now && (byte_in == BYTE_EXT || byte_in == BYTE_REL))
        |=> (!evt_valid && !unsup_stb));

    // R1: an event carries the code byte strobed one cycle earlier
    p_code_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_code == $past(byte_in)));
endmodule

// File: tb/sim_kbd_event_asm.sv
module sim_kbd_event_asm;
    localparam int CLK_PERIOD = 10;
    localparam int TAIL = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_stb = 1'b0;
    logic       evt_valid, evt_ext, evt_rel, unsup_stb;
    logic [7:0] evt_code;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // bench model of the requirements
    bit m_ext, m_rel;
    int m_skip;

    kbd_event_asm #(.PAUSE_TAIL(TAIL)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_stb(byte_stb),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_ext(evt_ext),
        .evt_rel(evt_rel), .unsup_stb(unsup_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // compare all outputs against an expected set
    task automatic check(input string req, input bit v, input logic [7:0] c,
                         input bit e, input bit r, input bit u);
        n_chk++;
        if (evt_valid !== v || evt_code !== c || evt_ext !== e ||
            evt_rel !== r || unsup_stb !== u) begin
            n_bad++;
            $display("FAIL %s: got v=%b c=%h e=%b r=%b u=%b exp v=%b c=%h e=%b r=%b u=%b",
                     req, evt_valid, evt_code, evt_ext, evt_rel, unsup_stb,
                     v, c, e, r, u);
        end
    endtask

    // expected response to one strobed byte, following R1-R8 rules
    task automatic model(input logic [7:0] b, output bit v, output logic [7:0] c,
                         output bit e, output bit r, output bit u);
        v = 0; c = 8'h00; e = 0; r = 0; u = 0;
        if (m_skip > 0) begin
            u = 1; m_skip--;
        end else if (b == 8'hE1) begin
            u = 1; m_skip = TAIL; m_ext = 0; m_rel = 0;
        end else if (b == 8'hE0) begin
            m_ext = 1;
        end else if (b == 8'hF0) begin
            m_rel = 1;
        end else if (m_ext && (b == 8'h12 || b == 8'h59)) begin
            u = 1; m_ext = 0; m_rel = 0;
        end else begin
            v = 1; c = b; e = m_ext; r = m_rel; m_ext = 0; m_rel = 0;
        end
    endtask

    // strobe one byte at a negedge, check at the next negedge
    task automatic send(input logic [7:0] b, input string req);
        bit v, e, r, u;
        logic [7:0] c;
        model(b, v, c, e, r, u);
        byte_in = b; byte_stb = 1'b1;
        @(negedge clk);
        byte_stb = 1'b0;
        check(req, v, c, e, r, u);
    endtask

    // idle cycle with junk on byte_in (R9)
    task automatic gap(input logic [7:0] junk);
        byte_in = junk; byte_stb = 1'b0;
        @(negedge clk);
        check("R9", 0, 8'h00, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; byte_stb = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_ext = 0; m_rel = 0; m_skip = 0;
    endtask

    function automatic logic [7:0] pick(input int sel);
        case (sel % 10)
            0, 1:    return 8'hE0;
            2, 3:    return 8'hF0;
            4:       return 8'hE1;
            5:       return (sel[4]) ? 8'h12 : 8'h59;
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles exp completion", cycles);
                $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_ext = 0; m_rel = 0; m_skip = 0;
        @(negedge clk);
        @(negedge clk);
        check("R10", 0, 8'h00, 0, 0, 0);   // R10 reset state
        rst_n = 1'b1;
        gap(8'h1C);                         // R9 junk while no strobe

        // directed sequences
        send(8'h1C, "R1");                  // A key press
        send(8'hE0, "R5"); send(8'h75, "R2");
        send(8'hF0, "R5"); send(8'h1C, "R3");
        send(8'hE0, "R5"); send(8'hF0, "R5"); send(8'h75, "R4");
        send(8'h1C, "R4");                  // prefix cleared after event
        gap(8'hF0);
        check("R6", 0, 8'h00, 0, 0, 0);    // R6 one-cycle event, fields zero
        // PRINT SCREEN make: E0 12 E0 7C, break: E0 F0 7C E0 F0 12
        send(8'hE0, "R5"); send(8'h12, "R8");
        send(8'hE0, "R5"); send(8'h7C, "R2");
        send(8'hE0, "R5"); send(8'hF0, "R5"); send(8'h7C, "R4");
        send(8'hE0, "R5"); send(8'hF0, "R5"); send(8'h12, "R8");
        send(8'hE0, "R5"); send(8'h59, "R8");
        // unextended 12 is a real key
        send(8'h12, "R1");
        // PAUSE: E1 14 77 E1 F0 14 F0 77, opened inside a pending prefix
        send(8'hE0, "R5");
        send(8'hE1, "R7"); send(8'h14, "R7"); send(8'h77, "R7");
        send(8'hE1, "R7"); send(8'hF0, "R7"); send(8'h14, "R7");
        send(8'hF0, "R7"); send(8'h77, "R7");
        send(8'h1C, "R7");                  // resumes, prefix dropped
        // reset mid-prefix and mid-window
        send(8'hE0, "R5"); send(8'hF0, "R5");
        do_reset();
        check("R10", 0, 8'h00, 0, 0, 0);
        send(8'h2A, "R10");
        send(8'hE1, "R7"); send(8'h14, "R7");
        do_reset();
        send(8'h33, "R10");

        // constrained random stream
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 4) == 0)
                gap(8'($urandom_range(0, 255)));
            else
                send(pick(int'($urandom_range(0, 1023))), "R1-mix");
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule